// File: doc/BRIEF.md
# Clear-on-read event counter bank with byte holding register

This block keeps a small bank of 16-bit performance-monitoring counters, one per event strobe, and lets software read them over an 8-bit register bus. A count cannot be fetched in one access, so each read of a counter address returns the upper byte. In the same clock edge, the lower byte is copied into a single holding register shared by all counters, and the whole counter is cleared. Software then reads the holding register address to get the lower byte. Both bytes come from the same instant, so the two halves always belong together, even when events keep arriving between the two accesses.

An event strobe that is high in the same cycle as the clearing read is counted into the freshly cleared counter, so no event is lost. A counter that reaches its maximum stays there until it is read; it does not wrap. The read data is registered and is valid in the cycle after the read strobe.

Top module: `pmon_ror_bank`

## Requirements
- R1: After synchronous active-low reset, every counter reads 0, the holding register reads 0x00 and `rd_data` is 0x00.
- R2: Each clock cycle in which `evt_strobe[k]` is high adds one to counter k. No other counter changes.
- R3: A counter at 0xFFFF stays at 0xFFFF while further events arrive. It does not wrap.
- R4: A read with `rd_en` high and `rd_addr` = 0x60 + k (k < NUM_CNT) returns bits 15:8 of counter k on `rd_data` in the next cycle.
- R5: The same read loads bits 7:0 of counter k into the holding register. A read at address 0x6C returns the holding register on `rd_data` in the next cycle.
- R6: A read of counter k sets all 16 bits of counter k to zero at the same clock edge, so the next read of that counter returns only events counted after it.
- R7: If `evt_strobe[k]` is high in the cycle of a clearing read of counter k, the read returns the old value and the counter then holds 1.
- R8: Reading the holding register does not clear it. It keeps its value until the next read of any counter address replaces it.
- R9: A read at any other address returns 0x00 and changes no counter and not the holding register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_strobe | input | NUM_CNT | One event strobe per counter, counted once per high cycle |
| rd_addr | input | ADDR_W | Register read address |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| rd_data | output | BUS_W | Registered read data, valid the cycle after `rd_en` |

## Verification
`rd_data`, the holding register and the counter clear all take effect at the single clock edge that samples `rd_en`. The bench therefore raises the read strobe on a falling edge and samples `rd_data` shortly after the next rising edge. An event strobe held high across n rising edges must add exactly n. The pulse task drives strobes on falling edges for that reason, and the expected counts follow from the number of edges. The same-cycle case raises the event and the read together on one falling edge. It then expects the old count from that read and a count of 1 from the next read.

// File: rtl/pmon_pkg.sv
// Package: shared sizes for the clear-on-read counter bank.
// Assumes a counter is exactly two bus bytes wide.
package pmon_pkg;
    localparam int PMON_BUS_W = 8;
    localparam int PMON_CNT_W = 2 * PMON_BUS_W;
    localparam int PMON_ADDR_W = 8;
endpackage

// File: rtl/pmon_event_ctr.sv
// Module: one saturating event counter with a synchronous clear.
// A clear and an event in the same cycle leave the count at 1.
// Assumes clr is a single-cycle pulse from the read decoder.
module pmon_event_ctr #(
    parameter int W = pmon_pkg::PMON_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX_CNT = '1;

    // Count events, saturate at the maximum, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= {{(W-1){1'b0}}, evt};
        end else if (evt && cnt != MAX_CNT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && evt && cnt != MAX_CNT) |=> cnt == $past(cnt) + 1'b1);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == MAX_CNT) |=> cnt == MAX_CNT);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> cnt == '0);

    assert_evt_on_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt) |=> cnt == {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/pmon_rd_decode.sv
// Module: decodes a read access into a counter select or a holding select.
// Counter k sits at CNT_BASE + k. The holding register sits at HOLD_ADDR.
// Assumes HOLD_ADDR lies outside the counter range.
module pmon_rd_decode #(
    parameter int NUM_CNT = 4,
    parameter int ADDR_W = pmon_pkg::PMON_ADDR_W,
    parameter logic [ADDR_W-1:0] CNT_BASE = 8'h60,
    parameter logic [ADDR_W-1:0] HOLD_ADDR = 8'h6C,
    localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_en,
    output logic [NUM_CNT-1:0] cnt_sel,
    output logic [IDX_W-1:0]   cnt_idx,
    output logic               cnt_hit,
    output logic               hold_sel
);
    // One comparator per counter address.
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_sel
        assign cnt_sel[k] = rd_en && (rd_addr == ADDR_W'(CNT_BASE + k));
    end

    // Encode the selected counter as an index for the read mux.
    always_comb begin
        cnt_idx = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (cnt_sel[k]) cnt_idx = IDX_W'(k);
        end
    end

    assign cnt_hit = |cnt_sel;
    assign hold_sel = rd_en && (rd_addr == HOLD_ADDR);
endmodule

// File: rtl/pmon_ror_bank.sv
// Module: a bank of clear-on-read 16-bit event counters read over an 8-bit bus.
// A counter read returns the upper byte, moves the lower byte into the shared
// holding register and clears the counter, all at one clock edge.
// Assumes one read per cycle; rd_data is registered and holds between reads.
module pmon_ror_bank #(
    parameter int NUM_CNT = 4,
    parameter int BUS_W = pmon_pkg::PMON_BUS_W,
    parameter int ADDR_W = pmon_pkg::PMON_ADDR_W,
    parameter logic [ADDR_W-1:0] CNT_BASE = 8'h60,
    parameter logic [ADDR_W-1:0] HOLD_ADDR = 8'h6C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] evt_strobe,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_en,
    output logic [BUS_W-1:0]   rd_data
);
    localparam int CNT_W = 2 * BUS_W;
    localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

    logic [NUM_CNT-1:0] cnt_sel;
    logic [IDX_W-1:0]   cnt_idx;
    logic               cnt_hit;
    logic               hold_sel;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    logic [CNT_W-1:0]   sel_val;
    logic [BUS_W-1:0]   hold_q;

    pmon_rd_decode #(
        .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W),
        .CNT_BASE(CNT_BASE), .HOLD_ADDR(HOLD_ADDR)
    ) u_dec (
        .rd_addr(rd_addr), .rd_en(rd_en), .cnt_sel(cnt_sel),
        .cnt_idx(cnt_idx), .cnt_hit(cnt_hit), .hold_sel(hold_sel)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_ctr
        pmon_event_ctr #(.W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .evt(evt_strobe[k]),
            .clr(cnt_sel[k]), .cnt(cnt_val[k])
        );
    end

    // Pick the count of the counter being read.
    always_comb sel_val = cnt_val[cnt_idx];

    // Capture the lower byte on every counter read; keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (cnt_hit) begin
            hold_q <= sel_val[BUS_W-1:0];
        end
    end

    // Register the read data: upper byte, holding byte or zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (cnt_hit)       rd_data <= sel_val[CNT_W-1:BUS_W];
            else if (hold_sel) rd_data <= hold_q;
            else               rd_data <= '0;
        end
    end

    assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hit |=> rd_data == $past(sel_val[CNT_W-1:BUS_W]));

    assert_lsb_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_hit |=> hold_q == $past(sel_val[BUS_W-1:0]));

    assert_hold_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_hit |=> $stable(hold_q));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !cnt_hit && !hold_sel) |=> rd_data == '0);
endmodule

// File: tb/sim_pmon_ror_bank.sv
// Directed bench for the clear-on-read counter bank.
module sim_pmon_ror_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] evt_strobe = '0;
    logic [7:0] rd_addr = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    localparam logic [7:0] HOLD = 8'h6C;

    pmon_ror_bank u0 (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
        .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run exceeded %0d cycles, expected end before", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Single read: strobe on a falling edge, sample just after the rising edge.
    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        rd_en = 1'b1;
        @(posedge clk);
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Full value: counter upper byte, then the holding register.
    task automatic read_full(input int k, output int v);
        logic [7:0] hi, lo;
        do_read(8'h60 + 8'(k), hi);
        do_read(HOLD, lo);
        v = {hi, lo};
    endtask

    // Hold event strobes for n rising edges.
    task automatic pulse(input logic [3:0] mask, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            evt_strobe = mask;
        end
        @(negedge clk);
        evt_strobe = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        int v;
        #1 check("R1 rd_data after reset", rd_data, 0);
        do_read(HOLD, d);
        check("R1 holding after reset", d, 0);
        for (int k = 0; k < 4; k++) begin
            read_full(k, v);
            check("R1 counter after reset", v, 0);
        end
    endtask

    task automatic t_count;
        int v;
        pulse(4'b0001, 5);
        pulse(4'b0011, 295);
        read_full(0, v);
        check("R2 R4 R5 counter0 value", v, 300);
        read_full(1, v);
        check("R2 R4 R5 counter1 value", v, 295);
        read_full(0, v);
        check("R6 counter0 cleared by read", v, 0);
        read_full(2, v);
        check("R2 counter2 untouched", v, 0);
    endtask

    task automatic t_saturate;
        int v;
        pulse(4'b0100, 70000);
        read_full(2, v);
        check("R3 counter2 saturated", v, 16'hFFFF);
        read_full(2, v);
        check("R3 R6 counter2 cleared after saturation", v, 0);
    endtask

    task automatic t_same_cycle;
        logic [7:0] hi, lo;
        int v;
        pulse(4'b1000, 3);
        @(negedge clk);
        evt_strobe = 4'b1000;
        rd_addr = 8'h63;
        rd_en = 1'b1;
        @(posedge clk);
        #1 hi = rd_data;
        @(negedge clk);
        evt_strobe = '0;
        rd_en = 1'b0;
        do_read(HOLD, lo);
        check("R7 read returns old count", {hi, lo}, 3);
        read_full(3, v);
        check("R7 event in clearing cycle kept", v, 1);
    endtask

    task automatic t_holding;
        logic [7:0] d;
        int v;
        pulse(4'b0010, 16'h1234);
        do_read(8'h61, d);
        check("R4 upper byte of 0x1234", d, 8'h12);
        do_read(HOLD, d);
        check("R5 lower byte in holding", d, 8'h34);
        do_read(HOLD, d);
        check("R8 holding not cleared by read", d, 8'h34);
        do_read(8'h70, d);
        check("R9 unmapped read returns zero", d, 0);
        do_read(HOLD, d);
        check("R9 unmapped read keeps holding", d, 8'h34);
        pulse(4'b0001, 7);
        do_read(8'h7F, d);
        check("R9 unmapped read returns zero again", d, 0);
        read_full(0, v);
        check("R9 unmapped read leaves counter0", v, 7);
        do_read(8'h62, d);
        do_read(HOLD, d);
        check("R8 holding replaced by next counter read", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_saturate();
        t_same_cycle();
        t_holding();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule